// File: doc/BRIEF.md
# Byte-Command Register Slave over SPI

This block lets an external SPI host reach a 128-entry, 8-bit register file by sending short byte commands. Each command begins with an opcode byte, which may be followed by an address byte and one or more data bytes. The supported commands are:

- read
- write
- masked bit update
- restore-defaults
- a single-bit send strobe for transmit buffer 0

Two of the registers, an enable mask and an event flag word, combine to drive an active-low, level-type interrupt line back to the host.

The slave does not use SCK as a clock. It runs on its own system clock and passes SCK, chip select and SI through synchronizers before detecting edges. For this reason the system clock must be several times faster than SCK. The logic that would normally set the event flags or consume the send strobe lives elsewhere. Here only the register-side effects of the commands are modelled.

Top module: `spi_regcmd_slave`

## Requirements
- R1: After rst_n is released, every register reads 0x00 except the control register at 0x0F, which reads 0x80. In the same state int_n is 1 and so is 0.
- R2: Opcode 0x03 followed by an address byte returns that register's value on SO, most significant bit first. SI is sampled on rising SCK and SO changes after falling SCK.
- R3: Opcode 0x02 followed by an address byte and a data byte stores the data byte at that address.
- R4: While CS stays low, each further data byte of a read or write uses the next address. The address wraps from 0x7F to 0x00.
- R5: Opcode 0x05 followed by address, mask and data bytes replaces only the register bits whose mask bit is 1 with the corresponding data bits. All other bits keep their value.
- R6: Opcode 0xC0 returns every register to its R1 value.
- R7: Opcode 0x81 sets bit 3 of the buffer-0 send control register at 0x30 and leaves its other bits unchanged.
- R8: int_n is 0 while any bit of the flag register (0x2C) is 1 together with the same bit of the enable register (0x2B). It returns to 1 once no such pair remains, either because the host cleared the flag or because it cleared the enable.
- R9: An opcode other than those listed above changes no register. SO stays 0 for the rest of that CS-low period.
- R10: Raising CS ends a command. A partly shifted byte is discarded, and the next CS-low period starts again with an opcode byte.
- R11: Commands work the same in SPI mode 0,0 (SCK idles low) and mode 1,1 (SCK idles high).
- R12: so is 0 whenever CS has been high for at least four system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data into the slave |
| so | output | 1 | Serial data out of the slave |
| int_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that SCK, CS and SI are slow compared with the system clock:

- Each SCK level lasts long enough for the synchronizers to see every edge.
- SI is stable for several system clocks around each rising SCK.
- CS changes only while SCK is at its idle level.

The bench keeps to this by holding every SCK half-period for eight system clocks. It changes SI only together with a falling SCK and moves CS only with SCK idle, with at least one half-period of margin on each side.

// File: rtl/spi_regcmd_pkg.sv
package spi_regcmd_pkg;

   localparam logic [7:0] OP_READ   = 8'h03;
   localparam logic [7:0] OP_WRITE  = 8'h02;
   localparam logic [7:0] OP_MODIFY = 8'h05;
   localparam logic [7:0] OP_RESET  = 8'hC0;
   localparam logic [7:0] OP_SEND0  = 8'h81;

   typedef enum logic [3:0] {
      ST_OPCODE,
      ST_RD_ADDR,
      ST_RD_DATA,
      ST_WR_ADDR,
      ST_WR_DATA,
      ST_BM_ADDR,
      ST_BM_MASK,
      ST_BM_DATA,
      ST_HOLD
   } cmd_state_t;

endpackage

// File: rtl/spi_regcmd_sync.sv
module spi_regcmd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_active,
   output logic si_s
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_regcmd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sck_p;
   logic [STAGES-1:0] cs_p;
   logic [STAGES-1:0] si_p;
   logic              sck_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_p    <= '0;
         cs_p     <= '1;
         si_p     <= '0;
         sck_last <= 1'b0;
      end else begin
         sck_p    <= {sck_p[STAGES-2:0], sck};
         cs_p     <= {cs_p[STAGES-2:0], cs_n};
         si_p     <= {si_p[STAGES-2:0], si};
         sck_last <= sck_p[STAGES-1];
      end
   end

   assign sck_rise  =  sck_p[STAGES-1] & ~sck_last;
   assign sck_fall  = ~sck_p[STAGES-1] &  sck_last;
   assign cs_active = ~cs_p[STAGES-1];
   assign si_s      =  si_p[STAGES-1];

endmodule

// File: rtl/spi_regcmd_shifter.sv
module spi_regcmd_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              si_s,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              tx_load,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              so
);

   localparam int CNT_W = $clog2(BYTE_W);

   generate
      if ((1 << CNT_W) != BYTE_W) begin : g_bad_width
         $error("spi_regcmd_shifter: BYTE_W must be a power of two");
      end
   endgenerate

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic [BYTE_W-1:0] rx_next;

   assign rx_next = {rx_sh[BYTE_W-2:0], si_s};
   assign tx_load = cs_active & sck_fall & (bit_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (!cs_active) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            rx_sh   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
               rx_byte   <= rx_next;
               byte_done <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
      end else if (!cs_active) begin
         tx_sh <= '0;
      end else if (tx_load) begin
         tx_sh <= tx_byte;
      end else if (sck_fall) begin
         tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
   end

   assign so = tx_sh[BYTE_W-1];

endmodule

// File: rtl/spi_regcmd_decoder.sv
module spi_regcmd_decoder
   import spi_regcmd_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              byte_done,
   input  logic [7:0]        rx_byte,
   input  logic              tx_load,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        tx_byte,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic [7:0]        wr_mask,
   output logic              soft_rst,
   output logic              txreq
);

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
         $error("spi_regcmd_decoder: ADDR_W must be 1..8");
      end
   endgenerate

   cmd_state_t        state;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_OPCODE;
         addr_q <= '0;
         mask_q <= '0;
      end else if (!cs_active) begin
         state <= ST_OPCODE;
      end else begin
         if (byte_done) begin
            unique case (state)
               ST_OPCODE: begin
                  case (rx_byte)
                     OP_READ:   state <= ST_RD_ADDR;
                     OP_WRITE:  state <= ST_WR_ADDR;
                     OP_MODIFY: state <= ST_BM_ADDR;
                     default:   state <= ST_HOLD;
                  endcase
               end
               ST_RD_ADDR: begin
                  addr_q <= rx_byte[ADDR_W-1:0];
                  state  <= ST_RD_DATA;
               end
               ST_WR_ADDR: begin
                  addr_q <= rx_byte[ADDR_W-1:0];
                  state  <= ST_WR_DATA;
               end
               ST_WR_DATA: addr_q <= addr_q + 1'b1;
               ST_BM_ADDR: begin
                  addr_q <= rx_byte[ADDR_W-1:0];
                  state  <= ST_BM_MASK;
               end
               ST_BM_MASK: begin
                  mask_q <= rx_byte;
                  state  <= ST_BM_DATA;
               end
               ST_BM_DATA: state <= ST_HOLD;
               default:    state <= state;
            endcase
         end
         if (tx_load && state == ST_RD_DATA) begin
            addr_q <= addr_q + 1'b1;
         end
      end
   end

   assign rd_addr  = addr_q;
   assign tx_byte  = (state == ST_RD_DATA) ? rd_data : 8'h00;
   assign wr_en    = cs_active & byte_done &
                     (state == ST_WR_DATA || state == ST_BM_DATA);
   assign wr_addr  = addr_q;
   assign wr_data  = rx_byte;
   assign wr_mask  = (state == ST_BM_DATA) ? mask_q : 8'hFF;
   assign soft_rst = cs_active & byte_done & (state == ST_OPCODE) &
                     (rx_byte == OP_RESET);
   assign txreq    = cs_active & byte_done & (state == ST_OPCODE) &
                     (rx_byte == OP_SEND0);

endmodule

// File: rtl/spi_regcmd_regfile.sv
module spi_regcmd_regfile #(
   parameter int         DEPTH      = 128,
   parameter int         CTRL_ADDR  = 'h0F,
   parameter logic [7:0] CTRL_RESET = 8'h80,
   parameter int         IE_ADDR    = 'h2B,
   parameter int         IF_ADDR    = 'h2C,
   parameter int         TXCTL_ADDR = 'h30,
   parameter int         TXREQ_BIT  = 3,
   localparam int        ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        wr_mask,
   input  logic              txreq,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic [7:0]        ctrl_q,
   output logic [7:0]        ie_q,
   output logic [7:0]        if_q,
   output logic [7:0]        txctl_q
);

   generate
      if ((1 << ADDR_W) != DEPTH || DEPTH > 256) begin : g_bad_depth
         $error("spi_regcmd_regfile: DEPTH must be a power of two up to 256");
      end
      if (CTRL_ADDR >= DEPTH || IE_ADDR >= DEPTH ||
          IF_ADDR >= DEPTH || TXCTL_ADDR >= DEPTH) begin : g_bad_map
         $error("spi_regcmd_regfile: a special address lies outside the file");
      end
      if (IE_ADDR == IF_ADDR || TXCTL_ADDR == CTRL_ADDR) begin : g_alias
         $error("spi_regcmd_regfile: special registers overlap");
      end
      if (TXREQ_BIT > 7) begin : g_bad_bit
         $error("spi_regcmd_regfile: TXREQ_BIT must be 0..7");
      end
   endgenerate

   logic [7:0] mem [DEPTH];
   logic [7:0] merged;

   assign merged = (mem[wr_addr] & ~wr_mask) | (wr_data & wr_mask);

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      localparam logic [7:0]        INIT    = (i == CTRL_ADDR) ? CTRL_RESET : 8'h00;
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
      if (i == TXCTL_ADDR) begin : g_txctl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[i] <= INIT;
            end else if (soft_rst) begin
               mem[i] <= INIT;
            end else if (wr_en && wr_addr == MY_ADDR) begin
               mem[i] <= merged;
            end else if (txreq) begin
               mem[i][TXREQ_BIT] <= 1'b1;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[i] <= INIT;
            end else if (soft_rst) begin
               mem[i] <= INIT;
            end else if (wr_en && wr_addr == MY_ADDR) begin
               mem[i] <= merged;
            end
         end
      end
   end

   assign rd_data = mem[rd_addr];
   assign ctrl_q  = mem[CTRL_ADDR];
   assign ie_q    = mem[IE_ADDR];
   assign if_q    = mem[IF_ADDR];
   assign txctl_q = mem[TXCTL_ADDR];

endmodule

// File: rtl/spi_regcmd_slave.sv
module spi_regcmd_slave #(
   parameter int         DEPTH       = 128,
   parameter int         SYNC_STAGES = 2,
   parameter int         CTRL_ADDR   = 'h0F,
   parameter logic [7:0] CTRL_RESET  = 8'h80,
   parameter int         IE_ADDR     = 'h2B,
   parameter int         IF_ADDR     = 'h2C,
   parameter int         TXCTL_ADDR  = 'h30,
   parameter int         TXREQ_BIT   = 3,
   localparam int        ADDR_W      = $clog2(DEPTH)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   output logic so,
   output logic int_n
);

   logic              sck_rise, sck_fall, cs_active, si_s;
   logic              tx_load, byte_done;
   logic [7:0]        rx_byte, tx_byte, rd_data;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic              wr_en, soft_rst, txreq;
   logic [7:0]        wr_data, wr_mask;
   logic [7:0]        ctrl_q, ie_q, if_q, txctl_q;
   logic              int_q;

   spi_regcmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .sck_rise(sck_rise), .sck_fall(sck_fall),
      .cs_active(cs_active), .si_s(si_s)
   );

   spi_regcmd_shifter #(.BYTE_W(8)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
      .tx_byte(tx_byte), .tx_load(tx_load), .byte_done(byte_done),
      .rx_byte(rx_byte), .so(so)
   );

   spi_regcmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
      .byte_done(byte_done), .rx_byte(rx_byte), .tx_load(tx_load),
      .rd_data(rd_data), .rd_addr(rd_addr), .tx_byte(tx_byte),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_mask(wr_mask), .soft_rst(soft_rst), .txreq(txreq)
   );

   spi_regcmd_regfile #(
      .DEPTH(DEPTH), .CTRL_ADDR(CTRL_ADDR), .CTRL_RESET(CTRL_RESET),
      .IE_ADDR(IE_ADDR), .IF_ADDR(IF_ADDR),
      .TXCTL_ADDR(TXCTL_ADDR), .TXREQ_BIT(TXREQ_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_mask(wr_mask), .txreq(txreq), .rd_addr(rd_addr),
      .rd_data(rd_data), .ctrl_q(ctrl_q), .ie_q(ie_q),
      .if_q(if_q), .txctl_q(txctl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_q <= 1'b1;
      else        int_q <= ~|(ie_q & if_q);
   end

   assign int_n = int_q;

endmodule

// File: rtl/spi_regcmd_checker.sv
module spi_regcmd_checker #(
   parameter int         ADDR_W     = 7,
   parameter int         IE_ADDR    = 'h2B,
   parameter logic [7:0] CTRL_RESET = 8'h80,
   parameter int         TXREQ_BIT  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              so,
   input logic              int_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic [7:0]        wr_mask,
   input logic              soft_rst,
   input logic              txreq,
   input logic [7:0]        ctrl_q,
   input logic [7:0]        ie_q,
   input logic [7:0]        if_q,
   input logic [7:0]        txctl_q
);

   p_so_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so);

   p_int_assert_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ie_q & if_q)) |=> !int_n);

   p_int_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(ie_q & if_q)) |=> int_n);

   p_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl_q == CTRL_RESET && ie_q == 8'h00 && if_q == 8'h00));

   p_masked_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(IE_ADDR)) |=>
      ie_q == (($past(ie_q) & ~$past(wr_mask)) | ($past(wr_data) & $past(wr_mask))));

   p_ie_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !soft_rst) |=> $stable(ie_q));

   p_send_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      txreq |=> txctl_q[TXREQ_BIT]);

   p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, soft_rst, txreq}));

endmodule

bind spi_regcmd_slave spi_regcmd_checker #(
   .ADDR_W(ADDR_W), .IE_ADDR(IE_ADDR),
   .CTRL_RESET(CTRL_RESET), .TXREQ_BIT(TXREQ_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .int_n(int_n),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
   .soft_rst(soft_rst), .txreq(txreq), .ctrl_q(ctrl_q), .ie_q(ie_q),
   .if_q(if_q), .txctl_q(txctl_q)
);

// File: tb/sim_spi_regcmd_slave.sv
`timescale 1ns/1ps
module sim_spi_regcmd_slave;

   localparam int HALF  = 8;
   localparam int WATCH = 150000;

   // {addr, initial value, mask, data, expected}
   localparam logic [39:0] MOD_VEC [6] = '{
      40'h10_A5_F0_3C_35,
      40'h11_FF_0F_00_F0,
      40'h12_00_FF_5A_5A,
      40'h13_81_00_7E_81,
      40'h14_3C_81_FF_BD,
      40'h15_5F_AA_00_55
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0;
   logic cs_n = 1'b1;
   logic si = 1'b0;
   logic so, int_n;
   logic cpol = 1'b0;
   logic finished = 1'b0;
   int   errors = 0;
   int   checks = 0;
   logic [7:0] fr_tx [8];
   logic [7:0] fr_rx [8];

   always #5 clk = ~clk;

   spi_regcmd_slave u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
      .si(si), .so(so), .int_n(int_n)
   );

   task automatic half_wait();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic spi_byte(input logic [7:0] d, input int nbits, output logic [7:0] r);
      r = 8'h00;
      for (int i = 7; i >= 8 - nbits; i--) begin
         sck = 1'b0;
         si  = d[i];
         half_wait();
         r[i] = so;
         sck = 1'b1;
         half_wait();
      end
   endtask

   task automatic run_frame(input int n, input int last_bits);
      logic [7:0] r;
      cs_n = 1'b0;
      half_wait();
      for (int k = 0; k < n; k++) begin
         spi_byte(fr_tx[k], (k == n - 1) ? last_bits : 8, r);
         fr_rx[k] = r;
      end
      if (!cpol) sck = 1'b0;
      half_wait();
      cs_n = 1'b1;
      half_wait();
      half_wait();
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      fr_tx[0] = 8'h02; fr_tx[1] = a; fr_tx[2] = d;
      run_frame(3, 8);
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
      fr_tx[0] = 8'h03; fr_tx[1] = a; fr_tx[2] = 8'h00;
      run_frame(3, 8);
      d = fr_rx[2];
   endtask

   task automatic modify_reg(input logic [7:0] a, input logic [7:0] m, input logic [7:0] d);
      fr_tx[0] = 8'h05; fr_tx[1] = a; fr_tx[2] = m; fr_tx[3] = d;
      run_frame(4, 8);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (WATCH) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      check8("R1 so after reset", {7'd0, so}, 8'h00);
      check8("R1 int_n after reset", {7'd0, int_n}, 8'h01);
      rd_reg(8'h0F, v); check8("R1 control default", v, 8'h80);
      rd_reg(8'h2B, v); check8("R1 enable default", v, 8'h00);
      rd_reg(8'h30, v); check8("R1 send ctl default", v, 8'h00);

      // R5 table of masked updates, then read back (R2, R3)
      for (int t = 0; t < 6; t++) begin
         wr_reg(MOD_VEC[t][39:32], MOD_VEC[t][31:24]);
         modify_reg(MOD_VEC[t][39:32], MOD_VEC[t][23:16], MOD_VEC[t][15:8]);
         rd_reg(MOD_VEC[t][39:32], v);
         check8($sformatf("R5 modify vector %0d", t), v, MOD_VEC[t][7:0]);
      end

      // R2 R3 plain write and read
      wr_reg(8'h40, 8'hC7);
      rd_reg(8'h40, v); check8("R3 R2 write then read", v, 8'hC7);
      check8("R12 so idle after read", {7'd0, so}, 8'h00);

      // R4 burst with wrap
      fr_tx[0] = 8'h02; fr_tx[1] = 8'h7E; fr_tx[2] = 8'h11; fr_tx[3] = 8'h22; fr_tx[4] = 8'h33;
      run_frame(5, 8);
      fr_tx[0] = 8'h03; fr_tx[1] = 8'h7E; fr_tx[2] = 0; fr_tx[3] = 0; fr_tx[4] = 0;
      run_frame(5, 8);
      check8("R4 burst byte 0x7E", fr_rx[2], 8'h11);
      check8("R4 burst byte 0x7F", fr_rx[3], 8'h22);
      check8("R4 burst wrap 0x00", fr_rx[4], 8'h33);

      // R7 send strobe
      wr_reg(8'h30, 8'h41);
      fr_tx[0] = 8'h81; run_frame(1, 8);
      rd_reg(8'h30, v); check8("R7 send bit set", v, 8'h49);

      // R8 interrupt line
      wr_reg(8'h2B, 8'h04);
      check8("R8 enable only", {7'd0, int_n}, 8'h01);
      wr_reg(8'h2C, 8'h06);
      check8("R8 flag and enable", {7'd0, int_n}, 8'h00);
      modify_reg(8'h2C, 8'h04, 8'h00);
      check8("R8 flag cleared", {7'd0, int_n}, 8'h01);
      wr_reg(8'h2C, 8'h04);
      check8("R8 flag again", {7'd0, int_n}, 8'h00);
      wr_reg(8'h2B, 8'h00);
      check8("R8 enable cleared", {7'd0, int_n}, 8'h01);

      // R9 unknown opcode
      fr_tx[0] = 8'h7F; fr_tx[1] = 8'h40; fr_tx[2] = 8'h99;
      run_frame(3, 8);
      check8("R9 so quiet byte 1", fr_rx[1], 8'h00);
      check8("R9 so quiet byte 2", fr_rx[2], 8'h00);
      rd_reg(8'h40, v); check8("R9 register unchanged", v, 8'hC7);

      // R10 abort mid-byte
      wr_reg(8'h20, 8'h66);
      fr_tx[0] = 8'h02; fr_tx[1] = 8'h20; fr_tx[2] = 8'hFF;
      run_frame(3, 4);
      rd_reg(8'h20, v); check8("R10 partial byte dropped", v, 8'h66);

      // R11 mode 1,1
      cpol = 1'b1; sck = 1'b1;
      half_wait();
      wr_reg(8'h21, 8'hC3);
      rd_reg(8'h21, v); check8("R11 mode 1,1 write/read", v, 8'hC3);
      rd_reg(8'h0F, v); check8("R11 mode 1,1 control", v, 8'h80);
      cpol = 1'b0; sck = 1'b0;
      half_wait();

      // R6 restore defaults
      wr_reg(8'h2B, 8'h04);
      check8("R6 interrupt before reset", {7'd0, int_n}, 8'h00);
      fr_tx[0] = 8'hC0; run_frame(1, 8);
      check8("R6 interrupt after reset", {7'd0, int_n}, 8'h01);
      rd_reg(8'h0F, v); check8("R6 control restored", v, 8'h80);
      rd_reg(8'h2B, v); check8("R6 enable restored", v, 8'h00);
      rd_reg(8'h10, v); check8("R6 plain reg restored", v, 8'h00);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule